// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Free-Running Timebase

This peripheral supervises software through a watchdog that runs for a period of 2^INTERVAL clock cycles. When the period ends for the first time without service, the block sets an expired flag and holds an interrupt line high. This gives software one more period to react. If the count runs out a second time while the flag is still set, the block drives a fixed-length system reset pulse and records that the reset happened. The worst-case time from the last service to a reset is therefore two periods.

Software reaches the block over a plain word-wide write/read bus. Control/status register 0 sits at byte offset 0x0 and holds two status bits and both enable bits. Register 1 sits at offset 0x4 and repeats the second enable bit. Offset 0x8 returns a free-running timebase count that software can use to confirm the clock is alive.

Writing a 1 to either status bit clears that bit and restarts the count, which is how software services the watchdog. The watchdog runs while either enable bit is set. A build option makes it enable-once: after it has started, writes that would stop it are ignored.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, offsets 0x0, 0x4 and 0xC read 0, `irq` is low and `sysReset` is low.
- R2: Offset 0x0 reads {28'b0, rstStatus, expired, enA, enB}, with bit 3 as rstStatus, bit 2 as expired, bit 1 as enA and bit 0 as enB. Offset 0x4 reads {31'b0, enB}, and writing its bit 0 sets enB. Offset 0xC and all unused bits read 0.
- R3: The watchdog runs while enA or enB is 1. 2^INTERVAL cycles after the enabling write, the first expiry sets expired, and `irq` equals expired from then on.
- R4: Writing offset 0x0 with bit 2 or bit 3 at 1 clears the matching status bit and restarts the count from zero. A write to offset 0x0 with both of those bits at 0 neither clears status nor restarts the count.
- R5: An expiry that occurs while expired is already 1 starts a `sysReset` pulse. With no service, the pulse begins 2·2^INTERVAL cycles after enabling.
- R6: `sysReset` stays high for exactly RST_PULSE cycles. rstStatus (bit 3) is set when the pulse starts and stays set after the pulse ends, until software writes a 1 to bit 3.
- R7: Without the enable-once option, the watchdog stops only when both enA and enB are 0. Clearing just one of them leaves the count running.
- R8: With LOCK_ONCE=1, once either enable bit has been set, writes that would clear enA or enB are ignored. Writes that set an enable bit still take effect.
- R9: Offset 0x8 reads a counter that rises by one every clock cycle, whatever state the watchdog is in. Writes to offset 0x8 have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register (combinational) |
| irq | output | 1 | High while the expired flag is set |
| sysReset | output | 1 | System reset pulse, RST_PULSE cycles long |

## Verification
The bench builds two instances with INTERVAL=6, so one period is 64 cycles, and RST_PULSE=16. One instance has LOCK_ONCE=0 and the other has LOCK_ONCE=1, so the stop rules and the enable-once rule are both exercised. The short period lets the bench check first and second expiries at their exact cycles, measure the full reset pulse, and run random keepalive gaps just under one period many times. Comparing the pair shows that the same clearing writes stop one instance and leave the other running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes sent from the control block to the datapath.
  typedef struct packed {
    logic run;        // count advances this cycle
    logic kick;       // restart the count from zero
    logic fireReset;  // start the system reset pulse
  } wdtStrobes_t;

  typedef enum logic [1:0] {
    REG_CS0   = 2'd0,
    REG_CS1   = 2'd1,
    REG_TBASE = 2'd2,
    REG_NONE  = 2'd3
  } regSel_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int LOCK_ONCE = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  regSel_t     regSel,
  input  logic [3:0]  wrBits,
  input  logic        expiry,
  output wdtStrobes_t strobes,
  output logic        enA,
  output logic        enB,
  output logic        expired,
  output logic        rstStatus
);
  logic wrCs0, wrCs1, kick, expiryEff, lockActive;
  logic enANext, enBNext;

  assign wrCs0 = wrEn && (regSel == REG_CS0);
  assign wrCs1 = wrEn && (regSel == REG_CS1);
  assign kick  = wrCs0 && (wrBits[3] || wrBits[2]);
  assign expiryEff = expiry && !kick;

  // The lock flag exists only when the enable-once option is built in.
  generate
    if (LOCK_ONCE != 0) begin : g_lock
      logic armed;
      always_ff @(posedge clk) begin
        if (!rstN) armed <= 1'b0;
        else       armed <= armed | enANext | enBNext;
      end
      assign lockActive = armed;
    end else begin : g_nolock
      assign lockActive = 1'b0;
    end
  endgenerate

  always_comb begin
    enANext = enA;
    enBNext = enB;
    if (wrCs0) begin
      enANext = lockActive ? (enA | wrBits[1]) : wrBits[1];
      enBNext = lockActive ? (enB | wrBits[0]) : wrBits[0];
    end
    if (wrCs1) begin
      enBNext = lockActive ? (enB | wrBits[0]) : wrBits[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enA       <= 1'b0;
      enB       <= 1'b0;
      expired   <= 1'b0;
      rstStatus <= 1'b0;
    end else begin
      enA <= enANext;
      enB <= enBNext;
      if (wrCs0 && wrBits[2])   expired <= 1'b0;
      else if (expiryEff)       expired <= 1'b1;
      if (wrCs0 && wrBits[3])         rstStatus <= 1'b0;
      else if (expiryEff && expired)  rstStatus <= 1'b1;
    end
  end

  assign strobes.run       = enA | enB;
  assign strobes.kick      = kick;
  assign strobes.fireReset = expiryEff && expired;
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int INTERVAL  = 16,
  parameter int RST_PULSE = 16,
  parameter int TB_W      = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdtStrobes_t         strobes,
  output logic                expiry,
  output logic                sysReset,
  output logic [TB_W-1:0]     timebase,
  output logic [INTERVAL-1:0] wdCount
);
  localparam int PULSE_W = $clog2(RST_PULSE + 1);
  localparam logic [PULSE_W-1:0] PULSE_LOAD = PULSE_W'(RST_PULSE);

  logic [PULSE_W-1:0] pulseLeft;

  always_ff @(posedge clk) begin
    if (!rstN) timebase <= '0;
    else       timebase <= timebase + 1'b1;
  end

  // The count wraps to zero at the end of each period.
  always_ff @(posedge clk) begin
    if (!rstN)                           wdCount <= '0;
    else if (!strobes.run || strobes.kick) wdCount <= '0;
    else                                 wdCount <= wdCount + 1'b1;
  end

  assign expiry = strobes.run && (&wdCount);

  always_ff @(posedge clk) begin
    if (!rstN)                  pulseLeft <= '0;
    else if (strobes.fireReset) pulseLeft <= PULSE_LOAD;
    else if (pulseLeft != '0)   pulseLeft <= pulseLeft - 1'b1;
  end

  assign sysReset = (pulseLeft != '0);
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int INTERVAL  = 16,
  parameter int RST_PULSE = 16,
  parameter int LOCK_ONCE = 0,
  parameter int TB_W      = 32,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              sysReset
);
  regSel_t             regSel;
  wdtStrobes_t         strobes;
  logic                expiry, enA, enB, expired, rstStatus;
  logic [TB_W-1:0]     timebase;
  logic [INTERVAL-1:0] wdCount;
  logic                unusedBits;

  assign regSel     = regSel_t'(addr[3:2]);
  assign unusedBits = ^wdata[DATA_W-1:4] ^ ^addr[1:0];

  wdt_ctrl #(.LOCK_ONCE(LOCK_ONCE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .wrBits(wdata[3:0]), .expiry(expiry), .strobes(strobes),
    .enA(enA), .enB(enB), .expired(expired), .rstStatus(rstStatus)
  );

  wdt_datapath #(.INTERVAL(INTERVAL), .RST_PULSE(RST_PULSE), .TB_W(TB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .expiry(expiry),
    .sysReset(sysReset), .timebase(timebase), .wdCount(wdCount)
  );

  always_comb begin
    unique case (regSel)
      REG_CS0:   rdata = DATA_W'({rstStatus, expired, enA, enB});
      REG_CS1:   rdata = DATA_W'(enB);
      REG_TBASE: rdata = DATA_W'(timebase);
      default:   rdata = '0;
    endcase
  end

  assign irq = expired;
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk #(
  parameter int INTERVAL  = 16,
  parameter int RST_PULSE = 16,
  parameter int LOCK_ONCE = 0
) (
  input logic                clk,
  input logic                rstN,
  input logic                irq,
  input logic                sysReset,
  input logic                rstStatus,
  input logic                kick,
  input logic                run,
  input logic [INTERVAL-1:0] wdCount
);
  logic [15:0] highLen;

  always_ff @(posedge clk) begin
    if (!rstN)        highLen <= '0;
    else if (sysReset) highLen <= highLen + 1'b1;
    else              highLen <= '0;
  end

  AST_RESET_AFTER_EXPIRED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysReset) |-> $past(irq)); // R5
  AST_RESET_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysReset) |-> rstStatus); // R6
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysReset) |-> (highLen == 16'(RST_PULSE))); // R6
  AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> (wdCount == '0)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ((LOCK_ONCE != 0) && $past(run)) |-> run); // R8
endmodule

bind twostage_wdt twostage_wdt_chk #(
  .INTERVAL(INTERVAL), .RST_PULSE(RST_PULSE), .LOCK_ONCE(LOCK_ONCE)
) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .sysReset(sysReset),
  .rstStatus(rstStatus), .kick(strobes.kick), .run(strobes.run),
  .wdCount(wdCount)
);

// File: tb/twostage_wdt_test.sv
`timescale 1ns/1ps
module twostage_wdt_test;
  localparam int INTERVAL = 6;
  localparam int PER = 1 << INTERVAL;
  localparam int PULSE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEnA = 1'b0, wrEnB = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdataA, rdataB;
  logic irqA, irqB, srA, srB;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  twostage_wdt #(.INTERVAL(INTERVAL), .RST_PULSE(PULSE), .LOCK_ONCE(0)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEnA), .addr(addr), .wdata(wdata),
    .rdata(rdataA), .irq(irqA), .sysReset(srA));

  twostage_wdt #(.INTERVAL(INTERVAL), .RST_PULSE(PULSE), .LOCK_ONCE(1)) uutLock (
    .clk(clk), .rstN(rstN), .wrEn(wrEnB), .addr(addr), .wdata(wdata),
    .rdata(rdataB), .irq(irqB), .sysReset(srB));

  function automatic logic [31:0] cs0(input bit rs, input bit ex, input bit ea, input bit eb);
    return {28'b0, rs, ex, ea, eb};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; commits on the next posedge; returns one negedge later.
  task automatic wr(input bit which, input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (which) wrEnB = 1'b1; else wrEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  task automatic rd(input bit which, input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = which ? rdataB : rdataA;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] v, t1, t2;
    void'($urandom(32'h5eed));
    waitN(4);
    rstN = 1'b1;
    waitN(1);

    // Reset state
    rd(0, 4'h0, v); chk("R1 cs0", v, 0);
    rd(0, 4'h4, v); chk("R1 cs1", v, 0);
    rd(0, 4'hC, v); chk("R1 hole", v, 0);
    chk("R1 irq", {31'b0, irqA}, 0);
    chk("R1 sysReset", {31'b0, srA}, 0);
    rd(1, 4'h0, v); chk("R1 lock cs0", v, 0);

    // Timebase advances one per cycle; writes to it are ignored
    for (int i = 0; i < 5; i++) begin
      int k = 1 + int'($urandom_range(40));
      rd(0, 4'h8, t1);
      waitN(k);
      rd(0, 4'h8, t2);
      chk("R9 timebase step", t2 - t1, k);
    end
    rd(0, 4'h8, t1);
    wr(0, 4'h8, 32'h0);
    waitN(2);
    rd(0, 4'h8, t2);
    chk("R9 write ignored", t2 - t1, 3);

    // First expiry after one period
    wr(0, 4'h0, 32'h2);
    waitN(PER - 1);
    chk("R3 no early irq", {31'b0, irqA}, 0);
    waitN(1);
    chk("R3 irq at expiry", {31'b0, irqA}, 1);
    rd(0, 4'h0, v); chk("R2 R3 cs0 expired", v, cs0(0, 1, 1, 0));
    rd(0, 4'h4, v); chk("R2 cs1 enB", v, 0);

    // Keepalive clears expired
    wr(0, 4'h0, 32'h6);
    chk("R4 irq cleared", {31'b0, irqA}, 0);
    rd(0, 4'h0, v); chk("R4 cs0 after kick", v, cs0(0, 0, 1, 0));

    // Random keepalive gaps below a period never expire
    for (int i = 0; i < 20; i++) begin
      waitN(1 + int'($urandom_range(PER - 4)));
      wr(0, 4'h0, 32'h6);
      chk("R4 random keepalive", {31'b0, irqA | srA}, 0);
    end

    // Writes with status bits 0 do not restart the count
    wr(0, 4'h0, 32'h2);
    waitN(PER - 2);
    chk("R4 zero write no kick, before", {31'b0, irqA}, 0);
    waitN(1);
    chk("R4 zero write no kick, expiry", {31'b0, irqA}, 1);

    // Second expiry raises the reset pulse
    waitN(PER - 1);
    chk("R5 no early reset", {31'b0, srA}, 0);
    waitN(1);
    chk("R5 reset at second expiry", {31'b0, srA}, 1);
    rd(0, 4'h0, v); chk("R6 status set", v, cs0(1, 1, 1, 0));
    waitN(PULSE - 1);
    chk("R6 pulse still high", {31'b0, srA}, 1);
    waitN(1);
    chk("R6 pulse ended", {31'b0, srA}, 0);
    rd(0, 4'h0, v); chk("R6 status survives", v, cs0(1, 1, 1, 0));
    wr(0, 4'h0, 32'hA);
    rd(0, 4'h0, v); chk("R6 status cleared by write", v, cs0(0, 1, 1, 0));
    wr(0, 4'h0, 32'h6);
    rd(0, 4'h0, v); chk("R4 expired cleared", v, cs0(0, 0, 1, 0));

    // Stop rules without the lock
    wr(0, 4'h0, 32'h7);
    wr(0, 4'h4, 32'h0);
    rd(0, 4'h0, v); chk("R7 one enable left", v, cs0(0, 0, 1, 0));
    waitN(PER - 2);
    chk("R7 still running, before", {31'b0, irqA}, 0);
    waitN(1);
    chk("R7 still running, expiry", {31'b0, irqA}, 1);
    wr(0, 4'h4, 32'h1);
    rd(0, 4'h4, v); chk("R2 cs1 write sets enB", v, 1);
    wr(0, 4'h0, 32'h4);
    rd(0, 4'h0, v); chk("R7 both cleared", v, 0);
    waitN(3 * PER);
    chk("R7 stopped no irq", {31'b0, irqA}, 0);
    chk("R7 stopped no reset", {31'b0, srA}, 0);

    // Enable-once instance
    wr(1, 4'h4, 32'h1);
    wr(1, 4'h0, 32'h4);
    rd(1, 4'h0, v); chk("R8 clear ignored cs0", v, cs0(0, 0, 0, 1));
    wr(1, 4'h4, 32'h0);
    rd(1, 4'h4, v); chk("R8 clear ignored cs1", v, 1);
    waitN(PER - 2);
    chk("R8 running, before", {31'b0, irqB}, 0);
    waitN(1);
    chk("R8 running, expiry", {31'b0, irqB}, 1);
    wr(1, 4'h0, 32'h6);
    rd(1, 4'h0, v); chk("R8 set allowed", v, cs0(0, 0, 1, 1));

    summary();
  end
endmodule